// File: doc/BRIEF.md
# PCI Type 0 Configuration Register File

This block holds the configuration header of a PCI target function and sits behind the target port of a PCI core. It does not follow raw bus phases. The core tells it where each transaction starts with an address-valid pulse. It then marks a configuration read or write with a level flag, and marks each completed data phase with an address-increment strobe. The block keeps the dword index from the start address and advances it on every strobe. On a configuration write it stores one dword per strobe, under the active-low byte enables. During a configuration read it drives the addressed dword onto a dedicated read-data bus.

The header holds identification values fixed at elaboration, a Command register and a Latency Timer. It also holds a parameterised set of 32-bit Base Address Registers. Each BAR is fixed as memory or I/O space and has a power-of-two size. The memory-enable and I/O-enable bits of the Command register, the Latency Timer and the BAR bases are driven out as ports. The address decoder uses them to gate target selection, and the master side uses the Latency Timer for its latency counter.

Top module: `cfg_type0_regfile`

## Requirements
- R1: After reset, both space enables are 0, the Latency Timer is 0, and every BAR reads back as 0 except bit 0, which is 1 for an I/O BAR.
- R2: The dword at byte offset 00h reads {DEVICE_ID[15:0], VENDOR_ID[15:0]}. The dword at 08h reads {CLASS_CODE[23:0], REVISION_ID[7:0]}. Writes to either dword change nothing.
- R3: The dword at offset 04h holds the Command register. Bit 1 is the memory-space enable, driven on `mem_space_en`. Bit 0 is the I/O-space enable, driven on `io_space_en`. All other bits of this dword read 0.
- R4: The Latency Timer occupies bits [15:8] of the dword at offset 0Ch and is driven on `lat_timer`. All other bits of that dword read 0.
- R5: BAR n sits at byte offset 10h + 4n. Bits below its size (2^BAR_SIZE_LOG2 bytes) read 0 and cannot be written. Bit 0 reads 1 for an I/O BAR and 0 for a memory BAR. Bits [31:size] are writable, and the BAR value is driven on `bar_base[32n+31:32n]`.
- R6: A dword is written only on a cycle where `cfg_wr_active` and `tgt_addr_inc` are both high. The data comes from `tgt_ad`. `tgt_cbe_n[k]` low enables byte lane k (bits 8k+7..8k), and a high bit leaves that byte unchanged. Strobes without `cfg_wr_active` write nothing.
- R7: The dword index is loaded from `tgt_ad[7:2]` on a cycle with `tgt_addr_valid` high. It advances by one on each `tgt_addr_inc` strobe, so a burst reaches consecutive dwords.
- R8: Only Type 0 cycles are serviced. If `tgt_ad[1:0]` is not 00 when the address is latched, writes in that transaction are ignored and reads return 0.
- R9: Once a burst runs past dword 63 (offset 0FCh), all further writes in that transaction are ignored and reads return 0. Unimplemented dwords below that point also read 0 and ignore writes.
- R10: `cfg_rd_data` shows the addressed dword, with no added register, from the cycle after the index is loaded or advanced. It is 0 whenever `cfg_rd_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tgt_ad | input | 32 | Start address in the address phase, write data in data phases |
| tgt_cbe_n | input | 4 | Active-low byte enables in data phases |
| tgt_addr_valid | input | 1 | Start-of-transaction pulse; the address is valid on `tgt_ad` |
| tgt_addr_inc | input | 1 | Data-phase strobe; advances the dword index |
| cfg_wr_active | input | 1 | A configuration write transaction is in progress |
| cfg_rd_active | input | 1 | A configuration read transaction is in progress |
| cfg_rd_data | output | 32 | Configuration read data |
| mem_space_en | output | 1 | Command register memory-space enable |
| io_space_en | output | 1 | Command register I/O-space enable |
| lat_timer | output | 8 | Latency Timer value |
| bar_base | output | NUM_BAR*32 | All BAR values, BAR n in bits [32n+31:32n] |

## Verification
A write strobe sampled at a clock edge shows up one cycle later: the exported enables, the Latency Timer and the BAR bases change after that edge. Read data depends only on the index register, so it is due one edge after the address pulse or an increment strobe, with no further pipeline delay. The bench drives every input on the falling edge. It samples outputs one time unit after the next falling edge, so each check lands in the first cycle where the result is due. A bench model keeps its own index and register copy, and every read and export check compares against that model.

// File: rtl/cfgspace_pkg.sv
// Package: constants and helpers shared by the configuration register file.
// Assumes dword indices are counted from configuration offset 00h.
package cfgspace_pkg;

    localparam int IDX_W      = 7;   // 6 index bits plus an out-of-range flag
    localparam int DW_IDENT   = 0;   // device and vendor identification
    localparam int DW_COMMAND = 1;   // command and status
    localparam int DW_CLASS   = 2;   // class code and revision
    localparam int DW_LATENCY = 3;   // latency timer lives in byte 1
    localparam int DW_BAR0    = 4;   // first base address register
    localparam int MAX_BARS   = 6;

    // Merge new data into an old dword under active-low byte enables.
    function automatic logic [31:0] merge_bytes(input logic [31:0] old_v,
                                                input logic [31:0] new_v,
                                                input logic [3:0]  be_n);
        logic [31:0] res;
        for (int k = 0; k < 4; k++) begin
            res[8*k +: 8] = be_n[k] ? old_v[8*k +: 8] : new_v[8*k +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/cfg_index_tracker.sv
// Dword index tracker.
// Loads the dword index from address bits [7:2] at the start of a
// transaction and records whether the cycle is Type 0 (bits [1:0] == 00).
// Advances the index on each data strobe and saturates at 64, which marks
// an out-of-range index. Assumes the start pulse and the data strobe never
// share a cycle.
module cfg_index_tracker
    import cfgspace_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    input  logic [7:0]       addr_lo,
    output logic [IDX_W-1:0] idx,
    output logic             is_type0
);

    // Load, advance or hold the index and the Type 0 flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            is_type0 <= 1'b0;
        end else if (start) begin
            idx      <= {1'b0, addr_lo[7:2]};
            is_type0 <= (addr_lo[1:0] == 2'b00);
        end else if (step && !idx[IDX_W-1]) begin
            idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_bar_slot.sv
// One Base Address Register.
// Holds the writable address bits above the decoded size. Bits below the
// size are kept at zero, and bit 0 reports the space type (1 = I/O).
// Assumes SIZE_LOG2 >= 4 for memory space and >= 2 for I/O space.
module cfg_bar_slot
    import cfgspace_pkg::*;
#(
    parameter int   SIZE_LOG2 = 12,
    parameter logic IS_IO     = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic [3:0]  be_n,
    output logic [31:0] value
);

    localparam logic [31:0] ADDR_MASK = ~((32'h1 << SIZE_LOG2) - 32'h1);
    localparam logic [31:0] TYPE_BITS = {31'b0, IS_IO};

    logic [31:0] base_q;

    // Store only the address bits the size leaves writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_en) begin
            base_q <= merge_bytes(value, wdata, be_n) & ADDR_MASK;
        end
    end

    // Readback combines the base with the fixed type bits.
    always_comb begin
        value = base_q | TYPE_BITS;
    end

endmodule

// File: rtl/cfg_type0_regfile.sv
// Type 0 configuration register file for a PCI target back end.
// Decodes per-dword write strobes from the configuration-write flag and the
// data strobe. Holds the Command enables, the Latency Timer and NUM_BAR BARs,
// and multiplexes read data by dword index. BAR n uses the 5-bit field n of
// BAR_SIZE_LOG2 and bit n of BAR_IS_IO. Assumes the core raises the
// transaction flags only after the address pulse.
module cfg_type0_regfile
    import cfgspace_pkg::*;
#(
    parameter logic [15:0]          VENDOR_ID     = 16'hC0DE,
    parameter logic [15:0]          DEVICE_ID     = 16'h5A31,
    parameter logic [23:0]          CLASS_CODE    = 24'h118000,
    parameter logic [7:0]           REVISION_ID   = 8'h02,
    parameter int                   NUM_BAR       = 3,
    parameter logic [NUM_BAR*5-1:0] BAR_SIZE_LOG2 = {5'd20, 5'd8, 5'd12},
    parameter logic [NUM_BAR-1:0]   BAR_IS_IO     = 3'b010
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [31:0]          tgt_ad,
    input  logic [3:0]           tgt_cbe_n,
    input  logic                 tgt_addr_valid,
    input  logic                 tgt_addr_inc,
    input  logic                 cfg_wr_active,
    input  logic                 cfg_rd_active,
    output logic [31:0]          cfg_rd_data,
    output logic                 mem_space_en,
    output logic                 io_space_en,
    output logic [7:0]           lat_timer,
    output logic [NUM_BAR*32-1:0] bar_base
);

    localparam logic [IDX_W-1:0] IDX_CMD = IDX_W'(DW_COMMAND);
    localparam logic [IDX_W-1:0] IDX_LAT = IDX_W'(DW_LATENCY);

    logic [IDX_W-1:0] cur_idx;
    logic             cur_type0;
    logic             wr_stb;
    logic [1:0]       cmd_q;
    logic [7:0]       lat_q;
    logic [31:0]      rd_mux;

    // Track the addressed dword through the transaction.
    cfg_index_tracker u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tgt_addr_valid),
        .step     (tgt_addr_inc),
        .addr_lo  (tgt_ad[7:0]),
        .idx      (cur_idx),
        .is_type0 (cur_type0)
    );

    // Qualified write strobe: config write, data phase, Type 0, in range.
    always_comb begin
        wr_stb = cfg_wr_active && tgt_addr_inc && cur_type0 && !cur_idx[IDX_W-1];
    end

    // Command register: keep only the two space-enable bits from byte lane 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= 2'b00;
        end else if (wr_stb && cur_idx == IDX_CMD && !tgt_cbe_n[0]) begin
            cmd_q <= tgt_ad[1:0];
        end
    end

    // Latency Timer: byte lane 1 of its dword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= 8'h00;
        end else if (wr_stb && cur_idx == IDX_LAT && !tgt_cbe_n[1]) begin
            lat_q <= tgt_ad[15:8];
        end
    end

    // One BAR slot per configured BAR, each with its own write decode.
    for (genvar g = 0; g < NUM_BAR; g++) begin : g_bar
        localparam int SZ = int'(BAR_SIZE_LOG2[g*5 +: 5]);
        logic bar_wr;

        always_comb begin
            bar_wr = wr_stb && (cur_idx == IDX_W'(DW_BAR0 + g));
        end

        cfg_bar_slot #(
            .SIZE_LOG2 (SZ),
            .IS_IO     (BAR_IS_IO[g])
        ) u_bar (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bar_wr),
            .wdata (tgt_ad),
            .be_n  (tgt_cbe_n),
            .value (bar_base[g*32 +: 32])
        );
    end

    // Read multiplexer over the implemented dwords; all others read zero.
    always_comb begin
        rd_mux = '0;
        if (cur_idx == IDX_W'(DW_IDENT)) begin
            rd_mux = {DEVICE_ID, VENDOR_ID};
        end else if (cur_idx == IDX_CMD) begin
            rd_mux = {30'b0, cmd_q};
        end else if (cur_idx == IDX_W'(DW_CLASS)) begin
            rd_mux = {CLASS_CODE, REVISION_ID};
        end else if (cur_idx == IDX_LAT) begin
            rd_mux = {16'b0, lat_q, 8'b0};
        end else begin
            for (int i = 0; i < NUM_BAR; i++) begin
                if (cur_idx == IDX_W'(DW_BAR0 + i)) begin
                    rd_mux = bar_base[i*32 +: 32];
                end
            end
        end
    end

    // Gate the read bus with the read flag and the Type 0 qualifier.
    always_comb begin
        cfg_rd_data = (cfg_rd_active && cur_type0) ? rd_mux : 32'h0;
    end

    // Drive the exported controls.
    always_comb begin
        mem_space_en = cmd_q[1];
        io_space_en  = cmd_q[0];
        lat_timer    = lat_q;
    end

endmodule

// File: rtl/cfg_type0_regfile_checker.sv
// Checker for cfg_type0_regfile: temporal properties on the ports and on the
// index tracker outputs. Attached to every instance by the bind below.
module cfg_type0_regfile_checker #(
    parameter logic [15:0] VENDOR_ID = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID = 16'h5A31,
    parameter int          NUM_BAR   = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [31:0]           tgt_ad,
    input logic                  tgt_addr_valid,
    input logic                  tgt_addr_inc,
    input logic                  cfg_wr_active,
    input logic                  cfg_rd_active,
    input logic [6:0]            cur_idx,
    input logic                  cur_type0,
    input logic [31:0]           cfg_rd_data,
    input logic                  mem_space_en,
    input logic                  io_space_en,
    input logic [7:0]            lat_timer,
    input logic [NUM_BAR*32-1:0] bar_base
);

    // R6: without a config-write strobe no stored value moves.
    assert_no_stray_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr_active && tgt_addr_inc) |=> ($stable(mem_space_en) && $stable(io_space_en)
                                              && $stable(lat_timer) && $stable(bar_base)));

    // R8: strobes in a non-Type-0 transaction leave the registers alone.
    assert_type1_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_active && tgt_addr_inc && !cur_type0) |=> ($stable(mem_space_en) && $stable(io_space_en)
                                                          && $stable(lat_timer) && $stable(bar_base)));

    // R9: strobes past the last dword leave the registers alone.
    assert_past_end_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_active && tgt_addr_inc && cur_idx[6]) |=> ($stable(mem_space_en) && $stable(io_space_en)
                                                           && $stable(lat_timer) && $stable(bar_base)));

    // R7: the start pulse loads the index from address bits [7:2].
    assert_index_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_addr_valid |=> (cur_idx == {1'b0, $past(tgt_ad[7:2])}));

    // R7: each strobe advances the index by one while in range.
    assert_index_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_addr_inc && !tgt_addr_valid && !cur_idx[6]) |=> (cur_idx == $past(cur_idx) + 7'd1));

    // R2: identification dword read returns the fixed IDs.
    assert_ident_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_active && cur_type0 && cur_idx == 7'd0) |-> (cfg_rd_data == {DEVICE_ID, VENDOR_ID}));

    // R9: reads past the last dword return zero.
    assert_past_end_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_active && cur_idx[6]) |-> (cfg_rd_data == 32'h0));

endmodule

bind cfg_type0_regfile cfg_type0_regfile_checker #(
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID),
    .NUM_BAR   (NUM_BAR)
) u_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .tgt_ad         (tgt_ad),
    .tgt_addr_valid (tgt_addr_valid),
    .tgt_addr_inc   (tgt_addr_inc),
    .cfg_wr_active  (cfg_wr_active),
    .cfg_rd_active  (cfg_rd_active),
    .cur_idx        (cur_idx),
    .cur_type0      (cur_type0),
    .cfg_rd_data    (cfg_rd_data),
    .mem_space_en   (mem_space_en),
    .io_space_en    (io_space_en),
    .lat_timer      (lat_timer),
    .bar_base       (bar_base)
);

// File: tb/test_cfg_type0_regfile.sv
// Self-checking bench: directed corner cases plus seeded random transactions,
// compared against a bench-side model of the configuration header.
module test_cfg_type0_regfile;

    localparam int          CLK_PERIOD = 10;
    localparam int          NB         = 3;
    localparam logic [15:0] VEN        = 16'hC0DE;
    localparam logic [15:0] DEV        = 16'h5A31;
    localparam logic [23:0] CLS        = 24'h118000;
    localparam logic [7:0]  REV        = 8'h02;
    localparam int          SZ [NB]    = '{12, 8, 20};
    localparam logic [NB-1:0] IOB      = 3'b010;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       tgt_ad = '0;
    logic [3:0]        tgt_cbe_n = 4'hF;
    logic              tgt_addr_valid = 1'b0;
    logic              tgt_addr_inc = 1'b0;
    logic              cfg_wr_active = 1'b0;
    logic              cfg_rd_active = 1'b0;
    logic [31:0]       cfg_rd_data;
    logic              mem_space_en;
    logic              io_space_en;
    logic [7:0]        lat_timer;
    logic [NB*32-1:0]  bar_base;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model state
    logic [1:0]  m_cmd;
    logic [7:0]  m_lat;
    logic [31:0] m_bar [NB];
    int          b_idx;
    bit          b_type0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_type0_regfile #(
        .VENDOR_ID     (VEN),
        .DEVICE_ID     (DEV),
        .CLASS_CODE    (CLS),
        .REVISION_ID   (REV),
        .NUM_BAR       (NB),
        .BAR_SIZE_LOG2 ({5'd20, 5'd8, 5'd12}),
        .BAR_IS_IO     (IOB)
    ) i_cfg_type0_regfile (
        .clk            (clk),
        .rst_n          (rst_n),
        .tgt_ad         (tgt_ad),
        .tgt_cbe_n      (tgt_cbe_n),
        .tgt_addr_valid (tgt_addr_valid),
        .tgt_addr_inc   (tgt_addr_inc),
        .cfg_wr_active  (cfg_wr_active),
        .cfg_rd_active  (cfg_rd_active),
        .cfg_rd_data    (cfg_rd_data),
        .mem_space_en   (mem_space_en),
        .io_space_en    (io_space_en),
        .lat_timer      (lat_timer),
        .bar_base       (bar_base)
    );

    function automatic logic [31:0] bar_mask(input int i);
        return ~((32'h1 << SZ[i]) - 32'h1);
    endfunction

    function automatic logic [31:0] exp_read(input int idx, input bit t0);
        if (!t0 || idx >= 64) return 32'h0;
        if (idx == 0) return {DEV, VEN};
        if (idx == 1) return {30'b0, m_cmd};
        if (idx == 2) return {CLS, REV};
        if (idx == 3) return {16'b0, m_lat, 8'b0};
        if (idx >= 4 && idx < 4 + NB) return m_bar[idx-4];
        return 32'h0;
    endfunction

    task automatic model_reset();
        m_cmd = 2'b00;
        m_lat = 8'h00;
        for (int i = 0; i < NB; i++) m_bar[i] = {31'b0, IOB[i]};
    endtask

    task automatic model_write(input int idx, input logic [31:0] d, input logic [3:0] be_n);
        logic [31:0] mg;
        if (!b_type0 || idx >= 64) return;
        if (idx == 1 && !be_n[0]) m_cmd = d[1:0];
        if (idx == 3 && !be_n[1]) m_lat = d[15:8];
        if (idx >= 4 && idx < 4 + NB) begin
            mg = m_bar[idx-4];
            for (int k = 0; k < 4; k++) if (!be_n[k]) mg[8*k +: 8] = d[8*k +: 8];
            m_bar[idx-4] = (mg & bar_mask(idx-4)) | {31'b0, IOB[idx-4]};
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Compare every exported control with the model (R3, R4, R5).
    task automatic check_exports(input string req);
        check({req, " R3 mem_space_en"}, {31'b0, mem_space_en}, {31'b0, m_cmd[1]});
        check({req, " R3 io_space_en"},  {31'b0, io_space_en},  {31'b0, m_cmd[0]});
        check({req, " R4 lat_timer"},    {24'b0, lat_timer},    {24'b0, m_lat});
        for (int i = 0; i < NB; i++) check({req, " R5 bar_base"}, bar_base[i*32 +: 32], m_bar[i]);
    endtask

    // Address phase; mode 0 = config read, 1 = config write, 2 = other write.
    task automatic begin_txn(input logic [7:0] a, input int mode);
        @(negedge clk);
        tgt_addr_valid = 1'b1;
        tgt_ad = {24'h0, a};
        tgt_cbe_n = (mode == 0) ? 4'hA : 4'hB;
        @(negedge clk);
        tgt_addr_valid = 1'b0;
        cfg_rd_active = (mode == 0);
        cfg_wr_active = (mode == 1);
        b_idx = int'(a[7:2]);
        b_type0 = (a[1:0] == 2'b00);
    endtask

    task automatic end_txn();
        cfg_rd_active = 1'b0;
        cfg_wr_active = 1'b0;
        tgt_cbe_n = 4'hF;
        @(negedge clk);
    endtask

    task automatic step_idx();
        if (b_idx < 64) b_idx++;
    endtask

    task automatic data_write(input logic [31:0] d, input logic [3:0] be_n, input bit cfg);
        tgt_ad = d;
        tgt_cbe_n = be_n;
        tgt_addr_inc = 1'b1;
        @(negedge clk);
        tgt_addr_inc = 1'b0;
        if (cfg) model_write(b_idx, d, be_n);
        step_idx();
    endtask

    task automatic data_read(input string req);
        #1;
        check(req, cfg_rd_data, exp_read(b_idx, b_type0));
        tgt_addr_inc = 1'b1;
        @(negedge clk);
        tgt_addr_inc = 1'b0;
        step_idx();
    endtask

    task automatic read_burst(input logic [7:0] a, input int n, input string req);
        begin_txn(a, 0);
        for (int i = 0; i < n; i++) data_read(req);
        end_txn();
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        b_idx = 0;
        b_type0 = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values on the exports and by readback
        check_exports("R1 reset");
        read_burst(8'h00, 4 + NB, "R1 R2 reset readback");

        // R10: read bus is zero when no read is active
        #1;
        check("R10 idle read bus", cfg_rd_data, 32'h0);

        // R2: writes to identification dwords are ignored
        begin_txn(8'h00, 1);
        data_write(32'hFFFF_FFFF, 4'h0, 1'b1);
        data_write(32'h1234_5678, 4'h0, 1'b1);
        data_write(32'hFFFF_FFFF, 4'h0, 1'b1);
        end_txn();
        read_burst(8'h00, 3, "R2 ids after write");

        // R5: size probe with all ones
        begin_txn(8'h10, 1);
        for (int i = 0; i < NB; i++) data_write(32'hFFFF_FFFF, 4'h0, 1'b1);
        end_txn();
        check_exports("R5 size probe");
        read_burst(8'h10, NB, "R5 size probe readback");

        // R3 R6: lane 0 enables; an all-disabled write has no effect
        begin_txn(8'h04, 1);
        data_write(32'hFFFF_FF03, 4'b1110, 1'b1);
        end_txn();
        check_exports("R3 enables set");
        begin_txn(8'h04, 1);
        data_write(32'h0000_0000, 4'hF, 1'b1);
        end_txn();
        check_exports("R6 no lanes");
        read_burst(8'h04, 1, "R3 command readback");

        // R4: latency timer through lane 1 only
        begin_txn(8'h0C, 1);
        data_write(32'hFFFF_ABFF, 4'b1101, 1'b1);
        end_txn();
        check_exports("R4 latency");
        read_burst(8'h0C, 1, "R4 latency readback");

        // R6: strobes without the config-write flag write nothing
        begin_txn(8'h04, 2);
        data_write(32'h0, 4'h0, 1'b0);
        end_txn();
        check_exports("R6 non-config strobe");

        // R7: burst write across header and BARs, partial lanes
        begin_txn(8'h0C, 1);
        data_write(32'h0000_5500, 4'h0, 1'b1);
        data_write(32'hA5A5_A5A5, 4'b0011, 1'b1);
        data_write(32'h0000_1234, 4'h0, 1'b1);
        end_txn();
        check_exports("R7 burst");
        read_burst(8'h00, 4 + NB + 2, "R7 burst readback");

        // R8: non-Type-0 write and read
        begin_txn(8'h05, 1);
        data_write(32'h0, 4'h0, 1'b1);
        end_txn();
        check_exports("R8 type1 write");
        read_burst(8'h01, 2, "R8 type1 read");

        // R9: burst running past the last dword
        begin_txn(8'hFC, 1);
        data_write(32'hFFFF_FFFF, 4'h0, 1'b1);
        data_write(32'hFFFF_FFFF, 4'h0, 1'b1);
        end_txn();
        check_exports("R9 past end write");
        read_burst(8'hFC, 3, "R9 past end read");
        read_burst(8'h1C, 2, "R9 unimplemented read");

        // Random transactions
        for (int it = 0; it < 250; it++) begin
            logic [7:0] a;
            int len;
            a[7:2] = ($urandom_range(0, 9) < 7) ? 6'($urandom_range(0, 8)) : 6'($urandom_range(0, 63));
            a[1:0] = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            len = $urandom_range(1, 3);
            if ($urandom_range(0, 4) == 0) begin
                begin_txn(a, 2);
                for (int j = 0; j < len; j++) data_write($urandom(), 4'($urandom()), 1'b0);
            end else begin
                begin_txn(a, 1);
                for (int j = 0; j < len; j++) data_write($urandom(), 4'($urandom()), 1'b1);
            end
            end_txn();
            check_exports("R6 R7 random");
            read_burst({a[7:2], 2'b00}, len, "R5 R7 random readback");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule